// File: doc/BRIEF.md
# Dual-Bank Flash Command Controller

This block is the command state machine that sits between a host bus and a two-bank flash array model. It reads decoded bus write cycles as command sequences. From them it keeps a mode for each bank (array read, identification read, or shortened-program entry) and it starts program and erase jobs, which it hands to the array model as one-cycle requests. Program jobs carry an address and a data byte. Erase jobs carry a sector mask. A job keeps its bank busy for a fixed number of cycles. Cell timing is not modelled.

Reads are qualified on the same cycle they are requested. A read is granted unless its bank is busy, so one bank can be read while the other is being written. A running erase can be paused. While it is paused, every sector of its bank except the ones being erased can be read or programmed. When the high-voltage accelerate input is raised, both banks decode the short two-write program form and sector protection is overridden.

The address MSB selects the bank. Bank 0 is split into small sectors and bank 1 into larger sectors of uniform size.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset both banks are in array-read mode and no bank is busy. A read of any address is granted with `rd_id` low, and no request is issued.
- R2: Bank b (b = address bit 11) accepts a program after four writes: 0xAA to offset 0x555, then 0x55 to offset 0x2AA, then 0xA0 to offset 0x555, then the data byte to its target address. Here an offset means address bits 10..0. `pgm_req` pulses for one cycle after the data write, carrying that address and data, and the target bank stays busy for PGM_CYC cycles.
- R3: A read is refused (`rd_ok` low) while its bank is busy. A read to the other bank is granted in the same cycle.
- R4: Two unlock writes followed by 0x20 at offset 0x555 put a bank into bypass mode. In bypass mode, 0xA0 to any address followed by a data write programs. Writing 0xF0, or any byte other than 0xA0, leaves bypass mode.
- R5: While `acc_hv` is high, every bank decodes the two-write bypass program, and protected sectors can be programmed. When `acc_hv` falls, any half-entered program sequence is dropped and decoding returns to the bank's stored mode.
- R6: A program to a sector whose `sect_lock` bit is set is ignored when `acc_hv` is low. Locked sectors are removed from an erase mask, and an erase left with no sectors is not issued.
- R7: Sector erase is six writes. The first five are unlock, 0x80 at offset 0x555, and unlock again. The sixth is 0x30 to an address in the sector. Any further 0x30 write within ERS_WIN cycles adds its sector to the mask and restarts the window. When the window lapses, `ers_req` pulses with the mask. Every bank holding a selected sector is busy from the first 0x30 write until ERS_CYC cycles of running have completed.
- R8: When the sixth write of the erase sequence is 0x10 at offset 0x555 instead, `ers_req` pulses at once with every unlocked sector set, and both banks become busy.
- R9: Writing 0xB0 to a bank with a running erase pauses it. `ers_held` rises and the bank is no longer busy. Reads and programs to sectors outside the mask are accepted, while reads and programs to masked sectors are refused. Writing 0x30 to that bank resumes the erase with its remaining count.
- R10: Unlock followed by 0x90 at offset 0x555 switches that bank's reads to the ID register (`rd_id` high). The other bank is unaffected. Writing 0xF0 returns the bank to array read.
- R11: A write that breaks the expected sequence returns the addressed bank to array-read mode and discards the partial sequence.
- R12: In bank 0, sector index = address bits 10..8 (sectors 0-7). In bank 1, sector index = 8 + address bits 10..9 (sectors 8-11). Bit i of `ers_mask` and `sect_lock` refers to sector i.
- R13: A program sequence is ignored if its data write arrives while a program is running. A 0xB0 write to a bank with no running erase suspends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 12 | Write address |
| wr_data | input | 8 | Write data / command byte |
| rd_en | input | 1 | Read request this cycle |
| rd_addr | input | 12 | Read address |
| acc_hv | input | 1 | High-voltage accelerate flag |
| sect_lock | input | 12 | Per-sector protection |
| rd_ok | output | 1 | Read granted this cycle |
| rd_id | output | 1 | Granted read sources the ID register |
| bank_busy | output | 2 | Per-bank busy flags |
| ers_held | output | 1 | Erase is suspended |
| pgm_req | output | 1 | Program request pulse |
| pgm_addr | output | 12 | Program address |
| pgm_data | output | 8 | Program data |
| ers_req | output | 1 | Erase request pulse |
| ers_mask | output | 12 | Sectors of the current erase |

## Verification
The hardest state to reach is a program that runs while an erase is suspended. Getting there takes a six-write erase sequence and the lapse of the collection window, a suspend write sent while the erase is still running, and then a full program sequence aimed at a sector of the same bank that is outside the erase mask. The stimulus first waits a few cycles past the window so the erase is running. It then suspends, probes reads inside and outside the masked sector, tries a program into the masked sector that must be dropped, and finally runs one into an unmasked sector before resuming. The scoreboard catches any request that was not predicted.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int SMALL_AW = 8,
  parameter int LARGE_AW = 9,
  parameter int PGM_CYC  = 16,
  parameter int ERS_CYC  = 64,
  parameter int ERS_WIN  = 8,
  localparam int BANK_AW = ADDR_W - 1,
  localparam int NS0     = 1 << (BANK_AW - SMALL_AW),
  localparam int NS1     = 1 << (BANK_AW - LARGE_AW),
  localparam int NSEC    = NS0 + NS1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              acc_hv,
  input  logic [NSEC-1:0]   sect_lock,
  output logic              rd_ok,
  output logic              rd_id,
  output logic [1:0]        bank_busy,
  output logic              ers_held,
  output logic              pgm_req,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [7:0]        pgm_data,
  output logic              ers_req,
  output logic [NSEC-1:0]   ers_mask
);
  localparam int SEC_W = $clog2(NSEC);
  localparam int CNT_W = $clog2(PGM_CYC + ERS_CYC + ERS_WIN + 1);
  localparam logic [BANK_AW-1:0] UA1 = BANK_AW'(11'h555);
  localparam logic [BANK_AW-1:0] UA2 = BANK_AW'(11'h2AA);

  typedef enum logic [1:0] {M_READ, M_AUTO, M_BYP} mode_t;
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PD, S_E0, S_E1, S_E2} step_t;
  typedef enum logic [1:0] {E_IDLE, E_WIN, E_RUN, E_SUSP} ers_t;

  function automatic logic [SEC_W-1:0] sec_of(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1]) return SEC_W'(NS0) + SEC_W'(a[BANK_AW-1:LARGE_AW]);
    return SEC_W'(a[BANK_AW-1:SMALL_AW]);
  endfunction

  mode_t            mode [2];
  step_t            step [2];
  ers_t             ers_st;
  logic [CNT_W-1:0] ers_cnt, pgm_cnt;
  logic             pgm_busy, acc_q;

  logic             wb, rb, is555, is2aa, byp, ers_on, pgm_ok, ers_ok;
  logic [SEC_W-1:0] wsec, rsec;
  logic [NSEC-1:0]  wsec_oh, allow;
  logic [1:0]       hit;

  assign wb      = wr_addr[ADDR_W-1];
  assign rb      = rd_addr[ADDR_W-1];
  assign wsec    = sec_of(wr_addr);
  assign rsec    = sec_of(rd_addr);
  assign wsec_oh = NSEC'(1) << wsec;
  assign is555   = wr_addr[BANK_AW-1:0] == UA1;
  assign is2aa   = wr_addr[BANK_AW-1:0] == UA2;
  assign allow   = acc_hv ? '1 : ~sect_lock;
  assign hit     = {|ers_mask[NSEC-1:NS0], |ers_mask[NS0-1:0]};
  assign ers_on  = (ers_st == E_WIN) || (ers_st == E_RUN);
  assign byp     = acc_hv || (mode[wb] == M_BYP);

  assign bank_busy[0] = (pgm_busy && !pgm_addr[ADDR_W-1]) || (ers_on && hit[0]);
  assign bank_busy[1] = (pgm_busy &&  pgm_addr[ADDR_W-1]) || (ers_on && hit[1]);

  assign pgm_ok = !pgm_busy && (acc_hv || !sect_lock[wsec]) &&
                  ((ers_st == E_IDLE) || ((ers_st == E_SUSP) && !ers_mask[wsec]));
  assign ers_ok = !pgm_busy && (ers_st == E_IDLE);

  assign rd_ok    = rd_en && !bank_busy[rb] && !((ers_st == E_SUSP) && ers_mask[rsec]);
  assign rd_id    = rd_ok && !acc_hv && (mode[rb] == M_AUTO);
  assign ers_held = ers_st == E_SUSP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        mode[i] <= M_READ;
        step[i] <= S_IDLE;
      end
      ers_st   <= E_IDLE;
      ers_cnt  <= '0;
      ers_mask <= '0;
      ers_req  <= 1'b0;
      pgm_busy <= 1'b0;
      pgm_cnt  <= '0;
      pgm_req  <= 1'b0;
      pgm_addr <= '0;
      pgm_data <= '0;
      acc_q    <= 1'b0;
    end else begin
      pgm_req <= 1'b0;
      ers_req <= 1'b0;
      acc_q   <= acc_hv;

      if (pgm_busy) begin
        if (pgm_cnt == '0) pgm_busy <= 1'b0;
        else pgm_cnt <= pgm_cnt - 1'b1;
      end

      case (ers_st)
        E_WIN:
          if (ers_cnt == '0) begin
            if (|ers_mask) begin
              ers_st  <= E_RUN;
              ers_cnt <= CNT_W'(ERS_CYC - 1);
              ers_req <= 1'b1;
            end else begin
              ers_st <= E_IDLE;
            end
          end else ers_cnt <= ers_cnt - 1'b1;
        E_RUN:
          if (ers_cnt == '0) begin
            ers_st   <= E_IDLE;
            ers_mask <= '0;
          end else ers_cnt <= ers_cnt - 1'b1;
        default: ;
      endcase

      if (wr_en) begin
        if (ers_st == E_WIN) begin
          if (wr_data == 8'h30) begin
            ers_mask <= ers_mask | (wsec_oh & allow);
            ers_cnt  <= CNT_W'(ERS_WIN - 1);
            ers_st   <= E_WIN;
            ers_req  <= 1'b0;
          end
        end else if (bank_busy[wb]) begin
          if (wr_data == 8'hB0 && ers_st == E_RUN && hit[wb]) ers_st <= E_SUSP;
        end else if (wr_data == 8'h30 && ers_st == E_SUSP && hit[wb] &&
                     step[wb] == S_IDLE && !pgm_busy) begin
          ers_st <= E_RUN;
        end else if (byp) begin
          if (step[wb] == S_PD) begin
            step[wb] <= S_IDLE;
            if (pgm_ok) begin
              pgm_busy <= 1'b1;
              pgm_cnt  <= CNT_W'(PGM_CYC - 1);
              pgm_req  <= 1'b1;
              pgm_addr <= wr_addr;
              pgm_data <= wr_data;
            end
          end else if (wr_data == 8'hA0) begin
            step[wb] <= S_PD;
          end else begin
            step[wb] <= S_IDLE;
            if (!acc_hv) mode[wb] <= M_READ;
          end
        end else begin
          case (step[wb])
            S_IDLE:
              if (wr_data == 8'hAA && is555) step[wb] <= S_U1;
              else mode[wb] <= M_READ;
            S_U1, S_E1: begin
              if (wr_data == 8'h55 && is2aa) step[wb] <= (step[wb] == S_U1) ? S_U2 : S_E2;
              else begin
                step[wb] <= S_IDLE;
                mode[wb] <= M_READ;
              end
            end
            S_U2: begin
              step[wb] <= S_IDLE;
              if (!is555) mode[wb] <= M_READ;
              else case (wr_data)
                8'hA0: step[wb] <= S_PD;
                8'h80: step[wb] <= S_E0;
                8'h90: mode[wb] <= M_AUTO;
                8'h20: mode[wb] <= M_BYP;
                default: mode[wb] <= M_READ;
              endcase
            end
            S_PD: begin
              step[wb] <= S_IDLE;
              mode[wb] <= M_READ;
              if (pgm_ok) begin
                pgm_busy <= 1'b1;
                pgm_cnt  <= CNT_W'(PGM_CYC - 1);
                pgm_req  <= 1'b1;
                pgm_addr <= wr_addr;
                pgm_data <= wr_data;
              end
            end
            S_E0:
              if (wr_data == 8'hAA && is555) step[wb] <= S_E1;
              else begin
                step[wb] <= S_IDLE;
                mode[wb] <= M_READ;
              end
            S_E2: begin
              step[wb] <= S_IDLE;
              mode[wb] <= M_READ;
              if (wr_data == 8'h30 && ers_ok) begin
                ers_st   <= E_WIN;
                ers_cnt  <= CNT_W'(ERS_WIN - 1);
                ers_mask <= wsec_oh & allow;
              end else if (wr_data == 8'h10 && is555 && ers_ok && |allow) begin
                ers_st   <= E_RUN;
                ers_cnt  <= CNT_W'(ERS_CYC - 1);
                ers_mask <= allow;
                ers_req  <= 1'b1;
              end
            end
            default: step[wb] <= S_IDLE;
          endcase
        end
      end

      if (acc_q && !acc_hv) begin
        step[0] <= S_IDLE;
        step[1] <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int ADDR_W   = 12,
  parameter int SMALL_AW = 8,
  parameter int LARGE_AW = 9,
  localparam int BANK_AW = ADDR_W - 1,
  localparam int NS0     = 1 << (BANK_AW - SMALL_AW),
  localparam int NS1     = 1 << (BANK_AW - LARGE_AW),
  localparam int NSEC    = NS0 + NS1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_hv,
  input logic [NSEC-1:0]   sect_lock,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ok,
  input logic              rd_id,
  input logic [1:0]        bank_busy,
  input logic              ers_held,
  input logic              pgm_req,
  input logic [ADDR_W-1:0] pgm_addr,
  input logic              ers_req,
  input logic [NSEC-1:0]   ers_mask
);
  localparam int SEC_W = $clog2(NSEC);
  logic [SEC_W-1:0] psec;
  assign psec = pgm_addr[ADDR_W-1] ? SEC_W'(NS0) + SEC_W'(pgm_addr[BANK_AW-1:LARGE_AW])
                                   : SEC_W'(pgm_addr[BANK_AW-1:SMALL_AW]);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (bank_busy == 2'b00 && !pgm_req && !ers_req && !ers_held));

  // R2
  pgm_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> bank_busy[pgm_addr[ADDR_W-1]]);

  // R3
  read_idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |-> (rd_en && !bank_busy[rd_addr[ADDR_W-1]]));

  // R10
  id_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |-> (rd_ok && !acc_hv));

  // R6
  locked_pgm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> ($past(acc_hv) || !$past(sect_lock[psec])));

  // R7
  ers_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ers_req |-> (ers_mask != '0));

  // R9
  held_has_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ers_held |-> (ers_mask != '0 && !ers_req));

  // R13
  one_job_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_req && ers_req));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .SMALL_AW(SMALL_AW), .LARGE_AW(LARGE_AW)) u_chk (.*);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PGM = 16;
  localparam int ERS = 64;
  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic        acc_hv = 1'b0;
  logic [11:0] sect_lock = '0;
  logic        rd_ok, rd_id, ers_held, pgm_req, ers_req;
  logic [1:0]  bank_busy;
  logic [11:0] pgm_addr, ers_mask;
  logic [7:0]  pgm_data;

  flash_cmd_ctrl u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .acc_hv(acc_hv), .sect_lock(sect_lock),
    .rd_ok(rd_ok), .rd_id(rd_id), .bank_busy(bank_busy), .ers_held(ers_held),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .ers_req(ers_req), .ers_mask(ers_mask));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          is_ers;
    logic [11:0] addr;
    logic [7:0]  data;
    logic [11:0] mask;
    string       tag;
  } exp_t;

  exp_t  expq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  string cur = "R1";
  bit    done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_p(input logic [11:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    e.is_ers = 1'b0; e.addr = a; e.data = d; e.mask = '0; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic push_e(input logic [11:0] m, input string tag);
    exp_t e;
    e.is_ers = 1'b1; e.addr = '0; e.data = '0; e.mask = m; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock(input bit b);
    wr({b, 11'h555}, 8'hAA);
    wr({b, 11'h2AA}, 8'h55);
  endtask

  task automatic rd_chk(input logic [11:0] a, input bit ok, input bit id, input string tag);
    rd_en = 1'b1; rd_addr = a;
    #1;
    chk({tag, " rd_ok"}, 32'(rd_ok), 32'(ok));
    chk({tag, " rd_id"}, 32'(rd_id), 32'(id));
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && (pgm_req || ers_req)) begin
      exp_t e;
      if (expq.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL %s: unexpected request actual pgm=%0b ers=%0b addr=%0h mask=%0h expected none",
                 cur, pgm_req, ers_req, pgm_addr, ers_mask);
      end else begin
        e = expq.pop_front();
        if (e.is_ers) begin
          chk({e.tag, " ers_req"}, 32'(ers_req), 32'd1);
          chk({e.tag, " ers_mask"}, 32'(ers_mask), 32'(e.mask));
        end else begin
          chk({e.tag, " pgm_req"}, 32'(pgm_req), 32'd1);
          chk({e.tag, " pgm_addr"}, 32'(pgm_addr), 32'(e.addr));
          chk({e.tag, " pgm_data"}, 32'(pgm_data), 32'(e.data));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    cur = "R1";
    chk("R1 busy", 32'(bank_busy), 32'd0);
    chk("R1 held", 32'(ers_held), 32'd0);
    rd_chk(12'h010, 1, 0, "R1");
    rd_chk(12'hA10, 1, 0, "R1");

    // R2 four-write program in bank 0, R3 read-while-write
    cur = "R2";
    push_p(12'h123, 8'h5A, "R2");
    unlock(0); wr(12'h555, 8'hA0); wr(12'h123, 8'h5A);
    chk("R2 busy start", 32'(bank_busy), 32'b01);
    rd_chk(12'h900, 1, 0, "R3 other bank");
    rd_chk(12'h100, 0, 0, "R3 busy bank");
    idle(PGM - 1);
    chk("R2 busy last", 32'(bank_busy), 32'b01);
    idle(1);
    chk("R2 busy end", 32'(bank_busy), 32'b00);

    // R13 program engine busy: second program ignored
    cur = "R13";
    push_p(12'h200, 8'h11, "R13 first");
    unlock(0); wr(12'h555, 8'hA0); wr(12'h200, 8'h11);
    unlock(1); wr(12'hD55, 8'hA0); wr(12'h900, 8'h22);
    chk("R13 busy", 32'(bank_busy), 32'b01);
    idle(PGM + 2);

    // R11 broken sequence
    cur = "R11";
    unlock(0); wr(12'h555, 8'h55);
    wr(12'h555, 8'hA0); wr(12'h300, 8'h77);
    idle(3);
    chk("R11 no job", 32'(bank_busy), 32'd0);

    // R10 autoselect
    cur = "R10";
    unlock(1); wr(12'hD55, 8'h90);
    rd_chk(12'hA00, 1, 1, "R10 id bank");
    rd_chk(12'h100, 1, 0, "R10 other bank");
    wr(12'hA00, 8'hF0);
    rd_chk(12'hA00, 1, 0, "R10 after reset cmd");
    unlock(1); wr(12'hD55, 8'h90);
    wr(12'hA00, 8'h12);
    cur = "R11";
    rd_chk(12'hA00, 1, 0, "R11 autoselect dropped");

    // R4 bypass
    cur = "R4";
    unlock(0); wr(12'h555, 8'h20);
    push_p(12'h040, 8'h33, "R4");
    wr(12'h000, 8'hA0); wr(12'h040, 8'h33);
    idle(PGM + 2);
    wr(12'h000, 8'hF0);
    wr(12'h000, 8'hA0); wr(12'h041, 8'h44);
    idle(3);
    chk("R4 exited", 32'(bank_busy), 32'd0);

    // R6 protection
    cur = "R6";
    sect_lock = 12'h004;
    unlock(0); wr(12'h555, 8'hA0); wr(12'h250, 8'h55);
    idle(3);
    chk("R6 locked ignored", 32'(bank_busy), 32'd0);

    // R5 accelerate
    cur = "R5";
    acc_hv = 1'b1;
    push_p(12'h250, 8'h66, "R5 locked");
    wr(12'h250, 8'hA0); wr(12'h250, 8'h66);
    idle(PGM + 2);
    push_p(12'hC01, 8'h67, "R5 bank1");
    wr(12'hC00, 8'hA0); wr(12'hC01, 8'h67);
    idle(PGM + 2);
    wr(12'h000, 8'hA0);
    acc_hv = 1'b0;
    idle(1);
    wr(12'h001, 8'h68);
    idle(3);
    chk("R5 released", 32'(bank_busy), 32'd0);

    // R7 and R12 multi-sector erase with window
    cur = "R7";
    push_e(12'h202, "R12 mask");
    unlock(1); wr(12'hD55, 8'h80); unlock(1);
    wr(12'hA40, 8'h30);
    wr(12'h100, 8'h30);
    wr(12'h250, 8'h30);
    chk("R7 window busy", 32'(bank_busy), 32'b11);
    idle(WIN + ERS - 2);
    chk("R7 running", 32'(bank_busy), 32'b11);
    idle(6);
    chk("R7 done", 32'(bank_busy), 32'd0);

    // R9 suspend, R13 stray suspend
    cur = "R9";
    push_e(12'h400, "R9 erase");
    unlock(1); wr(12'hD55, 8'h80); unlock(1);
    wr(12'hC00, 8'h30);
    idle(WIN + 3);
    chk("R9 erasing", 32'(bank_busy), 32'b10);
    wr(12'h100, 8'hB0);
    chk("R13 stray suspend", 32'(ers_held), 32'd0);
    wr(12'hC00, 8'hB0);
    chk("R9 held", 32'(ers_held), 32'd1);
    chk("R9 not busy", 32'(bank_busy), 32'd0);
    rd_chk(12'hC10, 0, 0, "R9 erasing sector");
    rd_chk(12'hE00, 1, 0, "R9 other sector");
    unlock(1); wr(12'hD55, 8'hA0); wr(12'hC20, 8'h98);
    idle(2);
    chk("R9 masked pgm ignored", 32'(bank_busy), 32'd0);
    push_p(12'hE04, 8'h99, "R9 pgm");
    unlock(1); wr(12'hD55, 8'hA0); wr(12'hE04, 8'h99);
    chk("R9 pgm busy", 32'(bank_busy), 32'b10);
    idle(PGM + 2);
    wr(12'hC00, 8'h30);
    chk("R9 resumed", 32'(ers_held), 32'd0);
    chk("R9 resumed busy", 32'(bank_busy), 32'b10);
    idle(ERS + 2);
    chk("R9 finished", 32'(bank_busy), 32'd0);

    // R8 chip erase
    cur = "R8";
    push_e(12'hFFB, "R8");
    unlock(0); wr(12'h555, 8'h80); unlock(0); wr(12'h555, 8'h10);
    chk("R8 both busy", 32'(bank_busy), 32'b11);
    idle(ERS + 2);
    chk("R8 done", 32'(bank_busy), 32'd0);

    while (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      n_chk++; n_bad++;
      $display("FAIL %s: actual no request expected addr=%0h mask=%0h", e.tag, e.addr, e.mask);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule